// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block holds one 8-bit control register and the detection logic for four groups of external interrupt pins and one top-level interrupt pin. Software reads and writes the register over a plain select/write/data bus. Two 2-bit sensitivity codes pick the trigger condition for pairs of pin groups. Two polarity bits invert that condition for the low pin group of port A and port B only. Every pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with the value one clock earlier.

Each group raises one request line, which is the OR of its pin detections. The top-level pin has its own enable and its own edge choice. Writes to the sensitivity and polarity bits take effect only while both CPU interrupt-level inputs are 1. The edge choice of the top-level pin can change only while that pin is disabled.

Top module: `extirq_sense_ctrl`

## Requirements
- R1: After reset the register reads 00h, and with all pins held high no request is raised.
- R2: Bits 7:2 take the written value only on a write made while cpu_lvl is 2'b11. Any other write leaves them unchanged.
- R3: Bit 1 selects the top-level edge (0 falling, 1 rising). A write changes it only if bit 0 was 0 before that write, even when the same write also changes bit 0.
- R4: Every write sets bit 0 (top-level enable) to the written value. bus_rdata shows the register while bus_sel is 1 and reads 0 otherwise.
- R5: Groups without polarity use this code meaning: 00 falling edge or low level, 01 rising edge, 10 falling edge, 11 either edge. These groups are irq_grp[1] (port F pins, code in bits 4:3) and irq_grp[3] (port B pins 7:4, code in bits 7:6).
- R6: irq_grp[0] (port A pins 3:0) uses code bits 4:3 with polarity bit 2. irq_grp[2] (port B pins 3:0) uses code bits 7:6 with polarity bit 5. With polarity 1 the meaning is: 00 rising edge or high level, 01 falling edge, 10 rising edge, 11 either edge. With polarity 0 the meaning of R5 applies.
- R7: In a level mode a group request stays high for as long as any pin of that group holds the active level.
- R8: A group request is the OR of the detections of all pins in that group.
- R9: A pin edge raises its request from the second rising clock edge after the pin changes. The request lasts exactly one cycle.
- R10: irq_tli pulses for one cycle on the selected edge of tli_pin, with the same latency as R9. It stays 0 while bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, used together with bus_sel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cpu_lvl | input | 2 | CPU interrupt-level bits; 2'b11 unlocks bits 7:2 |
| pa_pins | input | A_W | Port A interrupt pins (group 0) |
| pf_pins | input | F_W | Port F interrupt pins (group 1) |
| pb_pins | input | B_W | Port B pins: low half group 2, high half group 3 |
| tli_pin | input | 1 | Top-level interrupt pin |
| irq_grp | output | 4 | Per-group interrupt requests |
| irq_tli | output | 1 | Top-level interrupt request |

## Verification
Two cases are hard to reach from the ports. The first is a write that clears the top-level enable and changes the edge select in the same cycle, which is the only case that exposes whether the old or the new enable value gates bit 1. The second is a polarity change on port A or port B while the pins sit at a level, which moves a low pin group and a high pin group onto different meanings of the same code. The stimulus reaches both with directed writes, then runs random register writes and random pin patterns. Each random write has a bias towards the unlocking level, so that every code and polarity pair meets every pin transition.

// File: rtl/extirq_sense_ctrl.sv
module extirq_sense_ctrl #(
  parameter int A_W = 4,
  parameter int F_W = 3,
  parameter int B_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [1:0]     cpu_lvl,
  input  logic [A_W-1:0] pa_pins,
  input  logic [F_W-1:0] pf_pins,
  input  logic [B_W-1:0] pb_pins,
  input  logic           tli_pin,
  output logic [3:0]     irq_grp,
  output logic           irq_tli
);
  localparam int BL_W  = B_W / 2;
  localparam int BH_W  = B_W - BL_W;
  localparam int OFS_F = A_W;
  localparam int OFS_B = A_W + F_W;
  localparam int OFS_H = OFS_B + BL_W;
  localparam int OFS_T = A_W + F_W + B_W;
  localparam int N_W   = OFS_T + 1;

  // mode word: {rise_en, fall_en, level_en, level_high}
  function automatic logic [3:0] mode_of(input logic [1:0] code, input logic inv);
    case (code)
      2'b00:   return inv ? 4'b1011 : 4'b0110;
      2'b01:   return inv ? 4'b0100 : 4'b1000;
      2'b10:   return inv ? 4'b1000 : 4'b0100;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic logic pin_det(input logic cur, input logic old, input logic [3:0] m);
    return (m[3] & cur & ~old) | (m[2] & ~cur & old) | (m[1] & (cur == m[0]));
  endfunction

  logic [7:0] ctrl_q;
  wire wr_en  = bus_sel & bus_wr;
  wire lvl_ok = &cpu_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (lvl_ok)     ctrl_q[7:2] <= bus_wdata[7:2];
      if (!ctrl_q[0]) ctrl_q[1]   <= bus_wdata[1];
      ctrl_q[0] <= bus_wdata[0];
    end
  end

  assign bus_rdata = bus_sel ? ctrl_q : 8'h00;

  logic [N_W-1:0] meta_q, sync_q, prev_q;
  wire  [N_W-1:0] pin_raw = {tli_pin, pb_pins, pf_pins, pa_pins};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  wire [3:0] mode_a  = mode_of(ctrl_q[4:3], ctrl_q[2]);
  wire [3:0] mode_f  = mode_of(ctrl_q[4:3], 1'b0);
  wire [3:0] mode_bl = mode_of(ctrl_q[7:6], ctrl_q[5]);
  wire [3:0] mode_bh = mode_of(ctrl_q[7:6], 1'b0);

  logic [OFS_T-1:0] hit;
  always_comb begin
    for (int i = 0; i < OFS_T; i++) begin
      logic [3:0] m;
      if (i < OFS_F)      m = mode_a;
      else if (i < OFS_B) m = mode_f;
      else if (i < OFS_H) m = mode_bl;
      else                m = mode_bh;
      hit[i] = pin_det(sync_q[i], prev_q[i], m);
    end
  end

  assign irq_grp[0] = |hit[0 +: A_W];
  assign irq_grp[1] = |hit[OFS_F +: F_W];
  assign irq_grp[2] = |hit[OFS_B +: BL_W];
  assign irq_grp[3] = |hit[OFS_H +: BH_W];

  wire tli_cur  = sync_q[OFS_T];
  wire tli_old  = prev_q[OFS_T];
  wire tli_edge = ctrl_q[1] ? (tli_cur & ~tli_old) : (~tli_cur & tli_old);
  assign irq_tli = ctrl_q[0] & tli_edge;
endmodule

// File: rtl/extirq_sense_chk.sv
module extirq_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [1:0] cpu_lvl,
  input logic [7:0] ctrl,
  input logic       irq_tli
);
  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && cpu_lvl == 2'b11) |=> $stable(ctrl[7:2]));

  a_r2_unlocked_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && cpu_lvl == 2'b11) |=> ctrl[7:2] == $past(bus_wdata[7:2]));

  a_r3_edge_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] |=> $stable(ctrl[1]));

  a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> ctrl[0] == $past(bus_wdata[0]));

  a_r10_tli_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tli |-> ctrl[0]);
endmodule

bind extirq_sense_ctrl extirq_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .cpu_lvl(cpu_lvl), .ctrl(ctrl_q), .irq_tli(irq_tli)
);

// File: tb/extirq_sense_ctrl_tb.sv
`timescale 1ns/1ps
module extirq_sense_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cpu_lvl = 2'b00;
  logic [3:0] pa_pins = '1;
  logic [2:0] pf_pins = '1;
  logic [7:0] pb_pins = '1;
  logic       tli_pin = 1'b1;
  logic [3:0] irq_grp;
  logic       irq_tli;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_ctrl = 8'h00;

  always #10 clk = ~clk;

  extirq_sense_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_lvl(cpu_lvl),
    .pa_pins(pa_pins), .pf_pins(pf_pins), .pb_pins(pb_pins),
    .tli_pin(tli_pin), .irq_grp(irq_grp), .irq_tli(irq_tli)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one pin under a code and polarity; o = value before, n = value now
  function automatic bit pin_hit(bit o, bit n, bit [1:0] code, bit inv);
    bit rise = !o && n;
    bit fall = o && !n;
    case (code)
      2'b00: return inv ? (rise || n) : (fall || !n);
      2'b01: return inv ? fall : rise;
      2'b10: return inv ? rise : fall;
      default: return rise || fall;
    endcase
  endfunction

  function automatic bit grp_hit(logic [7:0] o, logic [7:0] n, int w, bit [1:0] code, bit inv);
    bit r = 0;
    for (int i = 0; i < w; i++) r |= pin_hit(o[i], n[i], code, inv);
    return r;
  endfunction

  function automatic logic [3:0] exp_grp(logic [3:0] oa, logic [2:0] of_, logic [7:0] ob,
                                         logic [3:0] na, logic [2:0] nf, logic [7:0] nb);
    logic [3:0] e;
    e[0] = grp_hit({4'h0, oa}, {4'h0, na}, 4, m_ctrl[4:3], m_ctrl[2]);
    e[1] = grp_hit({5'h0, of_}, {5'h0, nf}, 3, m_ctrl[4:3], 1'b0);
    e[2] = grp_hit({4'h0, ob[3:0]}, {4'h0, nb[3:0]}, 4, m_ctrl[7:6], m_ctrl[5]);
    e[3] = grp_hit({4'h0, ob[7:4]}, {4'h0, nb[7:4]}, 4, m_ctrl[7:6], 1'b0);
    return e;
  endfunction

  function automatic bit exp_tli(bit o, bit n);
    return m_ctrl[0] && (m_ctrl[1] ? (!o && n) : (o && !n));
  endfunction

  task automatic reg_write(input logic [7:0] d, input logic [1:0] lvl);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_wdata = d; cpu_lvl = lvl;
    @(negedge clk);
    bus_wr = 0;
    if (lvl == 2'b11) m_ctrl[7:2] = d[7:2];
    if (!m_ctrl[0]) m_ctrl[1] = d[1];
    m_ctrl[0] = d[0];
    #1;
    chk(bus_rdata === m_ctrl, "R2/R3/R4 readback", bus_rdata, m_ctrl);
    bus_sel = 0;
    #1;
    chk(bus_rdata === 8'h00, "R4 deselected read", bus_rdata, 0);
  endtask

  task automatic pin_step(input logic [3:0] na, input logic [2:0] nf,
                          input logic [7:0] nb, input logic nt);
    logic [3:0] oa = pa_pins;
    logic [2:0] of_ = pf_pins;
    logic [7:0] ob = pb_pins;
    logic ot = tli_pin;
    logic [3:0] e;
    @(negedge clk);
    pa_pins = na; pf_pins = nf; pb_pins = nb; tli_pin = nt;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    e = exp_grp(oa, of_, ob, na, nf, nb);
    chk(irq_grp === e, "R5/R6/R8/R9 edge cycle", irq_grp, e);
    chk(irq_tli === exp_tli(ot, nt), "R10 tli edge cycle", irq_tli, exp_tli(ot, nt));
    @(negedge clk);
    e = exp_grp(na, nf, nb, na, nf, nb);
    chk(irq_grp === e, "R7/R9 after edge", irq_grp, e);
    chk(irq_tli === 1'b0, "R10 tli single pulse", irq_tli, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    bus_sel = 1; #1;
    chk(bus_rdata === 8'h00, "R1 reset register", bus_rdata, 0);
    bus_sel = 0;
    chk(irq_grp === 4'h0 && irq_tli === 1'b0, "R1 no request after reset", {irq_tli, irq_grp}, 0);

    // R2 locked writes keep bits 7:2
    reg_write(8'hFC, 2'b01);
    reg_write(8'hFC, 2'b10);
    reg_write(8'hA4, 2'b11);

    // R3 edge select frozen while enabled, old enable governs
    reg_write(8'hA5, 2'b11);
    reg_write(8'hA7, 2'b11);
    reg_write(8'hA6, 2'b11);
    reg_write(8'hA6, 2'b11);

    // R7 level hold: port A low-level group, polarity 0, code 00
    reg_write(8'h00, 2'b11);
    pin_step(4'b1110, 3'b111, 8'hFF, 1'b1);
    repeat (3) @(negedge clk);
    chk(irq_grp[0] === 1'b1, "R7 low level held", irq_grp[0], 1);
    pin_step(4'b1111, 3'b111, 8'hFF, 1'b1);

    // R6 polarity on port B low half only: code 00 pol 1 -> high-level on low half
    reg_write(8'h20, 2'b11);
    pin_step(4'hF, 3'h7, 8'hF0, 1'b1);
    pin_step(4'hF, 3'h7, 8'h0F, 1'b1);

    // R10 rising edge of tli, enabled and disabled
    reg_write(8'h2A, 2'b11);
    reg_write(8'h2B, 2'b11);
    pin_step(4'hF, 3'h7, 8'h0F, 1'b0);
    pin_step(4'hF, 3'h7, 8'h0F, 1'b1);
    reg_write(8'h2A, 2'b11);
    pin_step(4'hF, 3'h7, 8'h0F, 1'b0);
    pin_step(4'hF, 3'h7, 8'h0F, 1'b1);

    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] lvl = ($urandom_range(0, 2) != 0) ? 2'b11 : 2'($urandom);
        reg_write(8'($urandom), lvl);
      end else begin
        pin_step(4'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));
      end
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule